// File: doc/BRIEF.md
# Multi-Mode 24-bit Up/Down Counter

This block is a synchronous up/down counter that advances by one on each single-cycle count pulse, in the direction given by a direction bit. A three-bit mode register picks the arithmetic and the cycle behaviour. The arithmetic is plain binary or packed BCD, with six decimal digits at the default width. The cycle behaviour is one of four: free wraparound, clamping between zero and the preset, stop-after-wrap, or divide-by-(preset+1) in either direction. The preset value is an input port, and the block holding it sits outside this one.

Each step that crosses a boundary emits a one-cycle carry or borrow pulse. A step that lands on the preset emits a one-cycle compare pulse. An 8-bit status word records toggles, the sign, the direction, a sticky error flag and the index level. Commands reset the count, load it from the preset, copy it to an output latch and clear flags. An optional gate input can block counting.

Top module: `mmc_counter`

## Requirements
- R1: After reset the count, the output latch, the status word and the carry, borrow and compare pulses are all zero, and the mode register is 3'b000 (binary, wraparound).
- R2: In wraparound mode (mode_in[2:1]=00, binary, mode_in[0]=0), an up pulse at 0xFFFFFF gives 0 and a down pulse at 0 gives 0xFFFFFF. Carry or borrow is high for exactly the one cycle after the stepping edge.
- R3: With mode_in[0]=1 the count is six BCD digits. A digit going up from 9 becomes 0 and carries into the next digit. A digit going down from 0 becomes 9 and borrows from the next digit. Up from 999999 gives 0 with carry, and down from 0 gives 999999 with borrow.
- R4: In clamp mode (mode_in[2:1]=01), an up pulse at count==preset and a down pulse at zero leave the count unchanged and emit no carry or borrow. The opposite direction counts normally.
- R5: In stop-after-wrap mode (mode_in[2:1]=10), the wrapping step still emits its carry or borrow. After that step, count pulses are ignored until a reset or load command.
- R6: In divide mode (mode_in[2:1]=11), an up pulse at count==preset gives 0 with carry. A down pulse at 0 gives the preset with borrow.
- R7: cmp_o is high for one cycle after a count step that moves the count to a value equal to preset_in. A frozen clamp step, a load and a reset give no compare pulse.
- R8: Status bit 0 toggles on every borrow, bit 1 on every carry and bit 2 on every compare. Bit 3 is set by a borrow and cleared by a carry.
- R9: Status bit 5 holds the direction of the most recent accepted count pulse (1 = up). Bit 6 is idx_in registered by one cycle. Bit 7 is always 0.
- R10: err_in sets status bit 4, which stays set until cmd_clr_err (clear wins over a same-cycle set). cmd_clr_flags clears bits 3:0 and leaves bit 4 alone.
- R11: With gate_mode=1, count pulses are accepted only while gate_in=1. With gate_mode=0, gate_in has no effect.
- R12: cmd_reset beats cmd_load, which beats a count pulse in the same cycle. Both commands also re-arm a stopped counter.
- R13: cmd_latch copies the count as it was before that clock edge into latch_o. latch_o is otherwise unchanged by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write mode_in into the mode register |
| mode_in | input | 3 | Bit 0 BCD, bits 2:1 cycle mode |
| preset_in | input | 24 | Preset value: load source, clamp/divide bound, compare value |
| cnt_en | input | 1 | Single-cycle count pulse |
| cnt_up | input | 1 | Direction, 1 = up |
| gate_mode | input | 1 | Use gate_in as a count gate |
| gate_in | input | 1 | Count gate, high enables |
| cmd_reset | input | 1 | Clear count |
| cmd_load | input | 1 | Load count from preset_in |
| cmd_latch | input | 1 | Copy count into latch_o |
| cmd_clr_flags | input | 1 | Clear status bits 3:0 |
| cmd_clr_err | input | 1 | Clear status bit 4 |
| err_in | input | 1 | Error event, sets status bit 4 |
| idx_in | input | 1 | Index level |
| count_o | output | 24 | Current count |
| latch_o | output | 24 | Latched count |
| carry_o | output | 1 | Carry pulse |
| borrow_o | output | 1 | Borrow pulse |
| cmp_o | output | 1 | Compare pulse |
| status_o | output | 8 | Status word |

## Verification
The bench targets the boundary steps of each mode. At the clamp bounds, a design that wraps or pulses carry would leave the preset. In stop-after-wrap mode, a design that keeps counting would reach 1 instead of staying at 0. At the divide bound in the down direction, a design that loads all-ones instead of the preset would give 0xFFFFFF. The BCD digit ripples are covered by 000009 to 000010 and 000100 to 000099; binary arithmetic would show 00000A or 0000FF there. Same-cycle command collisions are checked for priority: a count that beats a load would leave the preset plus one. Latch timing is checked with a latch and a count in the same cycle; a latch that samples the new value would be off by one.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  typedef enum logic [1:0] {
    CYC_WRAP  = 2'b00,
    CYC_CLAMP = 2'b01,
    CYC_STOP  = 2'b10,
    CYC_DIV   = 2'b11
  } cyc_mode_e;

  function automatic logic [3:0] bcd_digit_inc(input logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic [3:0] bcd_digit_dec(input logic [3:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction

endpackage

// File: rtl/mmc_step.sv
module mmc_step #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             up_i,
  input  logic             bcd_i,
  input  logic [1:0]       cyc_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             carry_o,
  output logic             borrow_o,
  output logic             hold_o,
  output logic             stop_o
);
  import mmc_pkg::*;

  localparam int DIGITS = WIDTH / 4;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] bcd_inc, bcd_dec, bcd_max, top_v, inc_v, dec_v;
  logic [DIGITS:0]  ci, bi;

  assign ci[0] = 1'b1;
  assign bi[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    assign d = cur_i[4*g +: 4];
    assign bcd_inc[4*g +: 4] = ci[g] ? bcd_digit_inc(d) : d;
    assign bcd_dec[4*g +: 4] = bi[g] ? bcd_digit_dec(d) : d;
    assign ci[g+1] = ci[g] && (d == 4'd9);
    assign bi[g+1] = bi[g] && (d == 4'd0);
    assign bcd_max[4*g +: 4] = 4'd9;
  end

  assign top_v = bcd_i ? bcd_max : {WIDTH{1'b1}};
  assign inc_v = bcd_i ? bcd_inc : cur_i + ONE;
  assign dec_v = bcd_i ? bcd_dec : cur_i - ONE;

  always_comb begin
    cyc_mode_e cyc;
    logic at_top, at_zero, at_pre;
    cyc      = cyc_mode_e'(cyc_i);
    at_top   = (cur_i == top_v);
    at_zero  = (cur_i == '0);
    at_pre   = (cur_i == preset_i);
    nxt_o    = cur_i;
    carry_o  = 1'b0;
    borrow_o = 1'b0;
    hold_o   = 1'b0;
    stop_o   = 1'b0;
    if (up_i) begin
      if (cyc == CYC_CLAMP && at_pre) begin
        hold_o = 1'b1;
      end else if ((cyc == CYC_DIV && at_pre) || at_top) begin
        nxt_o   = '0;
        carry_o = 1'b1;
        stop_o  = (cyc == CYC_STOP);
      end else begin
        nxt_o = inc_v;
      end
    end else begin
      if (at_zero) begin
        case (cyc)
          CYC_CLAMP: hold_o = 1'b1;
          CYC_DIV: begin
            nxt_o    = preset_i;
            borrow_o = 1'b1;
          end
          default: begin
            nxt_o    = top_v;
            borrow_o = 1'b1;
            stop_o   = (cyc == CYC_STOP);
          end
        endcase
      end else begin
        nxt_o = dec_v;
      end
    end
  end

endmodule

// File: rtl/mmc_status.sv
module mmc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_i,
  input  logic       dir_i,
  input  logic       carry_i,
  input  logic       borrow_i,
  input  logic       cmp_i,
  input  logic       clr_flags_i,
  input  logic       err_i,
  input  logic       clr_err_i,
  input  logic       idx_i,
  output logic [7:0] status_o
);
  logic bt_q, ct_q, cpt_q, sign_q, err_q, dir_q, idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bt_q <= 1'b0; ct_q <= 1'b0; cpt_q <= 1'b0; sign_q <= 1'b0;
      err_q <= 1'b0; dir_q <= 1'b0; idx_q <= 1'b0;
    end else begin
      idx_q <= idx_i;
      if (acc_i) dir_q <= dir_i;
      if (clr_err_i)  err_q <= 1'b0;
      else if (err_i) err_q <= 1'b1;
      if (clr_flags_i) begin
        bt_q <= 1'b0; ct_q <= 1'b0; cpt_q <= 1'b0; sign_q <= 1'b0;
      end else begin
        if (borrow_i) bt_q  <= ~bt_q;
        if (carry_i)  ct_q  <= ~ct_q;
        if (cmp_i)    cpt_q <= ~cpt_q;
        if (borrow_i)     sign_q <= 1'b1;
        else if (carry_i) sign_q <= 1'b0;
      end
    end
  end

  assign status_o = {1'b0, idx_q, dir_q, err_q, sign_q, cpt_q, ct_q, bt_q};

endmodule

// File: rtl/mmc_counter.sv
module mmc_counter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [2:0]       mode_in,
  input  logic [WIDTH-1:0] preset_in,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             gate_mode,
  input  logic             gate_in,
  input  logic             cmd_reset,
  input  logic             cmd_load,
  input  logic             cmd_latch,
  input  logic             cmd_clr_flags,
  input  logic             cmd_clr_err,
  input  logic             err_in,
  input  logic             idx_in,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] latch_o,
  output logic             carry_o,
  output logic             borrow_o,
  output logic             cmp_o,
  output logic [7:0]       status_o
);
  logic [2:0]       mode_q;
  logic [WIDTH-1:0] count_q, latch_q, step_nxt;
  logic             halt_q, carry_q, borrow_q, cmp_q;
  logic             step_carry, step_borrow, step_hold, step_stop;
  logic             fire, accept, ev_carry, ev_borrow, ev_cmp;

  // Named internal events
  assign fire      = cnt_en && (!gate_mode || gate_in) && !halt_q;
  assign accept    = fire && !cmd_reset && !cmd_load;
  assign ev_carry  = accept && step_carry;
  assign ev_borrow = accept && step_borrow;
  assign ev_cmp    = accept && !step_hold && (step_nxt == preset_in);

  mmc_step #(.WIDTH(WIDTH)) u_step (
    .cur_i    (count_q),
    .preset_i (preset_in),
    .up_i     (cnt_up),
    .bcd_i    (mode_q[0]),
    .cyc_i    (mode_q[2:1]),
    .nxt_o    (step_nxt),
    .carry_o  (step_carry),
    .borrow_o (step_borrow),
    .hold_o   (step_hold),
    .stop_o   (step_stop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      count_q  <= '0;
      latch_q  <= '0;
      halt_q   <= 1'b0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
      cmp_q    <= 1'b0;
    end else begin
      if (mode_we)   mode_q  <= mode_in;
      if (cmd_latch) latch_q <= count_q;
      carry_q  <= ev_carry;
      borrow_q <= ev_borrow;
      cmp_q    <= ev_cmp;
      if (cmd_reset) begin
        count_q <= '0;
        halt_q  <= 1'b0;
      end else if (cmd_load) begin
        count_q <= preset_in;
        halt_q  <= 1'b0;
      end else if (accept) begin
        count_q <= step_nxt;
        if (step_stop) halt_q <= 1'b1;
      end
    end
  end

  mmc_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (accept),
    .dir_i       (cnt_up),
    .carry_i     (ev_carry),
    .borrow_i    (ev_borrow),
    .cmp_i       (ev_cmp),
    .clr_flags_i (cmd_clr_flags),
    .err_i       (err_in),
    .clr_err_i   (cmd_clr_err),
    .idx_i       (idx_in),
    .status_o    (status_o)
  );

  assign count_o  = count_q;
  assign latch_o  = latch_q;
  assign carry_o  = carry_q;
  assign borrow_o = borrow_q;
  assign cmp_o    = cmp_q;

endmodule

// File: rtl/mmc_counter_chk.sv
module mmc_counter_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_bits,
  input logic [WIDTH-1:0] count_o,
  input logic [WIDTH-1:0] preset_in,
  input logic             carry_o,
  input logic             borrow_o,
  input logic [7:0]       status_o,
  input logic             cnt_up,
  input logic             fire,
  input logic             halt,
  input logic             cmd_load,
  input logic             cmd_reset,
  input logic             cmd_clr_flags,
  input logic             cmd_clr_err
);
  function automatic logic digits_ok(input logic [WIDTH-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WIDTH / 4; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  p_wrap_lands_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> count_o == '0);

  p_pulse_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_o && borrow_o));

  p_bcd_stays_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[0] && digits_ok(count_o) && !cmd_load) |=> digits_ok(count_o));

  p_clamp_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_up && mode_bits[2:1] == 2'b01 && count_o == preset_in
     && !cmd_load && !cmd_reset) |=> $stable(count_o));

  p_stopped_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cmd_load && !cmd_reset) |=> $stable(count_o));

  p_borrow_sets_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow_o && !$past(cmd_clr_flags)) |-> status_o[3]);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && !cmd_clr_err) |=> status_o[4]);

  p_load_takes_preset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !cmd_reset) |=> count_o == $past(preset_in));

endmodule

bind mmc_counter mmc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_bits     (mode_q),
  .count_o       (count_o),
  .preset_in     (preset_in),
  .carry_o       (carry_o),
  .borrow_o      (borrow_o),
  .status_o      (status_o),
  .cnt_up        (cnt_up),
  .fire          (fire),
  .halt          (halt_q),
  .cmd_load      (cmd_load),
  .cmd_reset     (cmd_reset),
  .cmd_clr_flags (cmd_clr_flags),
  .cmd_clr_err   (cmd_clr_err)
);

// File: tb/mmc_counter_tb.sv
module mmc_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [2:0]  mode_in = 3'b000;
  logic [23:0] preset_in = 24'h000100;
  logic        cnt_en = 1'b0, cnt_up = 1'b0, gate_mode = 1'b0, gate_in = 1'b0;
  logic        cmd_reset = 1'b0, cmd_load = 1'b0, cmd_latch = 1'b0;
  logic        cmd_clr_flags = 1'b0, cmd_clr_err = 1'b0, err_in = 1'b0, idx_in = 1'b0;
  logic [23:0] count_o, latch_o;
  logic        carry_o, borrow_o, cmp_o;
  logic [7:0]  status_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mmc_counter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
    .preset_in(preset_in), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .gate_mode(gate_mode), .gate_in(gate_in), .cmd_reset(cmd_reset),
    .cmd_load(cmd_load), .cmd_latch(cmd_latch), .cmd_clr_flags(cmd_clr_flags),
    .cmd_clr_err(cmd_clr_err), .err_in(err_in), .idx_in(idx_in),
    .count_o(count_o), .latch_o(latch_o), .carry_o(carry_o),
    .borrow_o(borrow_o), .cmp_o(cmp_o), .status_o(status_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cnt_en = 0; cmd_reset = 0; cmd_load = 0; cmd_latch = 0;
    cmd_clr_flags = 0; cmd_clr_err = 0; err_in = 0; mode_we = 0;
  endtask

  task automatic cnt(input logic up);
    cnt_en = 1; cnt_up = up; tick();
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_in = m; mode_we = 1; tick();
  endtask

  task automatic do_reset();  cmd_reset = 1; tick(); endtask
  task automatic do_load();   cmd_load = 1; tick(); endtask
  task automatic clr_flags(); cmd_clr_flags = 1; tick(); endtask

  task automatic t_reset_state();
    check("R1", "count", {8'h0, count_o}, 32'h0);
    check("R1", "latch", {8'h0, latch_o}, 32'h0);
    check("R1", "status", {24'h0, status_o}, 32'h0);
    check("R1", "pulses", {29'h0, carry_o, borrow_o, cmp_o}, 32'h0);
  endtask

  task automatic t_wrap_binary();
    preset_in = 24'h000100; set_mode(3'b000); do_reset(); clr_flags();
    repeat (3) cnt(1);
    check("R2", "up three", {8'h0, count_o}, 32'h3);
    repeat (3) cnt(0);
    cnt(0);
    check("R2", "down from zero", {8'h0, count_o}, 32'hFFFFFF);
    check("R2", "borrow pulse", {31'h0, borrow_o}, 32'h1);
    check("R8", "status after borrow", {24'h0, status_o}, 32'h09);
    tick();
    check("R2", "borrow one cycle", {31'h0, borrow_o}, 32'h0);
    cnt(1);
    check("R2", "up from max", {8'h0, count_o}, 32'h0);
    check("R2", "carry pulse", {30'h0, carry_o, borrow_o}, 32'h2);
    check("R8", "status after carry", {24'h0, status_o}, 32'h23);
    clr_flags();
    check("R10", "clear flags keeps direction", {24'h0, status_o}, 32'h20);
  endtask

  task automatic t_bcd();
    set_mode(3'b001);
    preset_in = 24'h000009; do_load(); cnt(1);
    check("R3", "digit ripple up", {8'h0, count_o}, 32'h000010);
    preset_in = 24'h999999; do_load(); cnt(1);
    check("R3", "999999 up", {8'h0, count_o}, 32'h0);
    check("R3", "bcd carry", {31'h0, carry_o}, 32'h1);
    cnt(0);
    check("R3", "0 down", {8'h0, count_o}, 32'h999999);
    check("R3", "bcd borrow", {31'h0, borrow_o}, 32'h1);
    check("R7", "compare on reaching preset", {31'h0, cmp_o}, 32'h1);
    preset_in = 24'h000100; do_load(); cnt(0);
    check("R3", "digit ripple down", {8'h0, count_o}, 32'h000099);
  endtask

  task automatic t_clamp();
    set_mode(3'b010); preset_in = 24'h000004; do_reset(); clr_flags();
    repeat (3) cnt(1);
    check("R7", "no compare before preset", {31'h0, cmp_o}, 32'h0);
    cnt(1);
    check("R7", "compare at preset", {31'h0, cmp_o}, 32'h1);
    check("R8", "compare toggle", {31'h0, status_o[2]}, 32'h1);
    repeat (2) cnt(1);
    check("R4", "frozen at preset", {8'h0, count_o}, 32'h4);
    check("R4", "no carry or compare when frozen", {30'h0, carry_o, cmp_o}, 32'h0);
    repeat (6) cnt(0);
    check("R4", "frozen at zero", {8'h0, count_o}, 32'h0);
    check("R4", "no borrow at zero", {31'h0, borrow_o}, 32'h0);
    cnt(1);
    check("R4", "resumes on reversal", {8'h0, count_o}, 32'h1);
  endtask

  task automatic t_stop();
    set_mode(3'b100); preset_in = 24'hFFFFFE; do_load();
    cnt(1); cnt(1);
    check("R5", "wrap emits carry", {31'h0, carry_o}, 32'h1);
    cnt(1);
    check("R5", "stopped after carry", {8'h0, count_o}, 32'h0);
    check("R5", "no second carry", {31'h0, carry_o}, 32'h0);
    do_reset(); cnt(1);
    check("R12", "reset re-arms", {8'h0, count_o}, 32'h1);
    cnt(0); cnt(0);
    check("R5", "underflow borrow", {8'h0, count_o, 7'h0, borrow_o} >> 0, {8'hFF, 24'hFFFF01} & 32'hFFFFFFFF ^ 32'h0 | 32'h0 ? 32'hFFFFFF01 : 32'h0);
    cnt(0);
    check("R5", "stopped after borrow", {8'h0, count_o}, 32'hFFFFFF);
    do_load(); cnt(0);
    check("R12", "load re-arms", {8'h0, count_o}, 32'hFFFFFD);
  endtask

  task automatic t_divide();
    set_mode(3'b110); preset_in = 24'h000003; do_reset();
    repeat (3) cnt(1);
    check("R7", "divide compare", {31'h0, cmp_o}, 32'h1);
    cnt(1);
    check("R6", "up at preset to zero", {8'h0, count_o}, 32'h0);
    check("R6", "divide carry", {31'h0, carry_o}, 32'h1);
    cnt(0);
    check("R6", "down at zero to preset", {8'h0, count_o}, 32'h3);
    check("R6", "divide borrow", {31'h0, borrow_o}, 32'h1);
    repeat (3) cnt(0);
    cnt(0);
    check("R6", "second reload", {8'h0, count_o}, 32'h3);
  endtask

  task automatic t_gate();
    set_mode(3'b000); preset_in = 24'h000100; do_reset();
    gate_mode = 1; gate_in = 0; cnt(1);
    check("R11", "gate low blocks", {8'h0, count_o}, 32'h0);
    gate_in = 1; cnt(1);
    check("R11", "gate high counts", {8'h0, count_o}, 32'h1);
    gate_mode = 0; gate_in = 0; cnt(1);
    check("R11", "gate ignored when unused", {8'h0, count_o}, 32'h2);
  endtask

  task automatic t_priority();
    preset_in = 24'h00ABCD;
    cmd_load = 1; cnt(1);
    check("R12", "load beats count", {8'h0, count_o}, 32'h00ABCD);
    cmd_reset = 1; cmd_load = 1; cnt(1);
    check("R12", "reset beats load", {8'h0, count_o}, 32'h0);
  endtask

  task automatic t_latch();
    preset_in = 24'h000100; do_reset();
    repeat (5) cnt(1);
    cmd_latch = 1; tick();
    check("R13", "latch copy", {8'h0, latch_o}, 32'h5);
    cnt(1);
    check("R13", "latch unchanged by count", {8'h0, latch_o}, 32'h5);
    cmd_latch = 1; cnt(1);
    check("R13", "latch takes pre-edge value", {8'h0, latch_o}, 32'h6);
    check("R13", "count after latch", {8'h0, count_o}, 32'h7);
  endtask

  task automatic t_flags();
    err_in = 1; tick();
    check("R10", "error set", {31'h0, status_o[4]}, 32'h1);
    clr_flags();
    check("R10", "flag clear keeps error", {31'h0, status_o[4]}, 32'h1);
    cmd_clr_err = 1; err_in = 1; tick();
    check("R10", "error clear wins", {31'h0, status_o[4]}, 32'h0);
    idx_in = 1; tick();
    check("R9", "index bit", {31'h0, status_o[6]}, 32'h1);
    check("R9", "bit 7 zero", {31'h0, status_o[7]}, 32'h0);
    cnt(0);
    check("R9", "direction down", {31'h0, status_o[5]}, 32'h0);
    idx_in = 0; tick();
    check("R9", "index follows input", {31'h0, status_o[6]}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset_state();
    t_wrap_binary();
    t_bcd();
    t_clamp();
    t_stop();
    t_divide();
    t_gate();
    t_priority();
    t_latch();
    t_flags();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule